// File: doc/BRIEF.md
# Interrupt vector ring writer

This block gathers interrupt events from several sources and stores each one in a circular buffer in system memory as a fixed vector of four 32-bit words (16 bytes). Incoming events wait in a small FIFO. The block then writes each vector to memory as four sequential word writes on a simple valid/ready memory port. It keeps a byte-granular write pointer, and host software moves a byte-granular read pointer as it drains the ring. The block raises an interrupt line while unread vectors remain.

The host programs the 256-byte-aligned ring base, the ring length, the enables and an optional mirror address for the write pointer. It can also clear a sticky overflow flag, which sits in bit 0 of the readable write-pointer word. When the writer laps the reader it does not stop: it keeps overwriting the oldest vectors, so the newest events are always kept.

Top module: `irq_ring_writer`

## Requirements
- R1: A vector is packed as word 0 = {24'b0, source id[7:0]}, word 1 = {4'b0, source data[27:0]}, word 2 = {pasid[15:0], vmid[7:0], ring id[7:0]}, word 3 = 0.
- R2: Word k (k = 0..3) of a vector is written at byte address {cfg_base, 8'h00} + write pointer + 4*k, in the order 0,1,2,3, each held until accepted. The write pointer advances by 16 only after word 3 has been accepted.
- R3: The ring length is 2^cfg_log2 words (cfg_log2 is clamped to MAX_LOG2). Both the write pointer and any value written to the read pointer are masked to (4 * 2^cfg_log2) - 1 bytes, so the pointers wrap to 0.
- R4: irq is high while cfg_intr_en is set and the read pointer differs from the write pointer, and low otherwise.
- R5: With cfg_rearm set, irq is low in the cycle after a read-pointer write, and returns high in the following cycle if the pointers still differ. With cfg_rearm clear, a read-pointer write causes no such gap.
- R6: With cfg_ovf_en set, a vector whose completion makes the write pointer equal to the read pointer sets the overflow flag (wptr_stat bit 0). The writer keeps writing and overwrites the oldest entries. With cfg_ovf_en clear, the flag is not set.
- R7: The overflow flag stays set until ovf_clear is high. While ovf_clear is high the flag is held at 0 and is not set. Detection resumes once ovf_clear returns to 0.
- R8: With cfg_wb_en set, each vector is followed by a fifth write to cfg_wb_addr. That write carries the updated wptr_stat word: write pointer in bits [PTR_W-1:1], overflow flag in bit 0.
- R9: No memory write starts unless both cfg_intr_en and cfg_ring_en are set. Events stay queued until both are set.
- R10: The input FIFO holds FIFO_DEPTH events. When it is full, ev_ready is low and no event is lost. Vectors are written in arrival order.
- R11: A ptr_zero pulse resets both pointers to 0 only while cfg_ring_en is clear. While the ring is enabled, ptr_zero has no effect.
- R12: After reset wptr_stat = 0, irq = 0, mem_valid = 0 and ev_ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | FIFO can take an event |
| ev_src | input | 8 | Source id |
| ev_data | input | 28 | Source data |
| ev_ring | input | 8 | Ring id |
| ev_vmid | input | 8 | Virtual machine id |
| ev_pasid | input | 16 | Process address space id |
| cfg_intr_en | input | 1 | Global interrupt enable |
| cfg_ring_en | input | 1 | Ring enable |
| cfg_ovf_en | input | 1 | Overflow detection enable |
| cfg_wb_en | input | 1 | Write-pointer mirror enable |
| cfg_rearm | input | 1 | Re-arm irq on read-pointer write |
| cfg_base | input | 32 | Ring base, byte address bits [39:8] |
| cfg_log2 | input | LOG_W | log2 of ring length in words |
| cfg_wb_addr | input | 40 | Mirror byte address |
| ovf_clear | input | 1 | Overflow clear, active high |
| ptr_zero | input | 1 | Zero both pointers (ring disabled only) |
| rptr_we | input | 1 | Read-pointer write strobe |
| rptr_wdata | input | PTR_W | New read pointer, bytes |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts write |
| mem_addr | output | 40 | Write byte address |
| mem_data | output | 32 | Write data |
| wptr_stat | output | 32 | Write pointer with overflow flag in bit 0 |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted write pointer shows on the next vector's word addresses and at once on wptr_stat. A wrong read pointer shows on irq in the same cycle, because irq compares the two pointers directly. A pointer that moves early shows as a wptr_stat change while the memory port is still stalled between words. A lost or reordered FIFO entry shows as a wrong source id in word 0 of a later vector. An overflow flag that is wrongly set or cleared shows on wptr_stat bit 0, and in the mirror word one beat after the vector completes.

// File: rtl/irq_ring_writer.sv
module irq_ring_writer #(
  parameter int FIFO_DEPTH = 4,
  parameter int MAX_LOG2   = 16,
  localparam int PTR_W = MAX_LOG2 + 2,
  localparam int LOG_W = $clog2(MAX_LOG2 + 1),
  localparam int FA_W  = $clog2(FIFO_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [7:0]       ev_src,
  input  logic [27:0]      ev_data,
  input  logic [7:0]       ev_ring,
  input  logic [7:0]       ev_vmid,
  input  logic [15:0]      ev_pasid,
  input  logic             cfg_intr_en,
  input  logic             cfg_ring_en,
  input  logic             cfg_ovf_en,
  input  logic             cfg_wb_en,
  input  logic             cfg_rearm,
  input  logic [31:0]      cfg_base,
  input  logic [LOG_W-1:0] cfg_log2,
  input  logic [39:0]      cfg_wb_addr,
  input  logic             ovf_clear,
  input  logic             ptr_zero,
  input  logic             rptr_we,
  input  logic [PTR_W-1:0] rptr_wdata,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [39:0]      mem_addr,
  output logic [31:0]      mem_data,
  output logic [31:0]      wptr_stat,
  output logic             irq
);
  typedef enum logic [1:0] {S_IDLE, S_VEC, S_WB} st_t;

  st_t              state;
  logic [1:0]       widx;
  logic [67:0]      fifo_q [FIFO_DEPTH];
  logic [FA_W-1:0]  f_wr, f_rd;
  logic [FA_W:0]    f_cnt;
  logic [PTR_W-1:0] wptr, rptr, mask, wptr_nxt;
  logic             ovf, ovf_set, ovf_new, gap;
  logic [31:0]      wb_snap, vec_word;
  logic [67:0]      head;
  logic [LOG_W-1:0] lg;
  logic             push, commit, start;

  assign lg       = (cfg_log2 > LOG_W'(MAX_LOG2)) ? LOG_W'(MAX_LOG2) : cfg_log2;
  assign mask     = ~({PTR_W{1'b1}} << (lg + 2));
  assign wptr_nxt = (wptr + PTR_W'(16)) & mask;
  assign ev_ready = f_cnt != (FA_W+1)'(FIFO_DEPTH);
  assign push     = ev_valid && ev_ready;
  assign head     = fifo_q[f_rd];
  assign commit   = (state == S_VEC) && mem_ready && (widx == 2'd3);
  assign start    = (state == S_IDLE) && cfg_intr_en && cfg_ring_en && (f_cnt != '0);
  assign ovf_set  = commit && cfg_ovf_en && !ovf_clear && (wptr_nxt == rptr);
  assign ovf_new  = !ovf_clear && (ovf || ovf_set);

  assign wptr_stat = {{(32-PTR_W){1'b0}}, wptr[PTR_W-1:1], ovf};
  assign irq       = cfg_intr_en && (wptr != rptr) && !gap;
  assign mem_valid = state != S_IDLE;

  always_comb begin
    case (widx)
      2'd0:    vec_word = {24'd0, head[7:0]};
      2'd1:    vec_word = {4'd0, head[35:8]};
      2'd2:    vec_word = head[67:36];
      default: vec_word = '0;
    endcase
  end

  assign mem_data = (state == S_WB) ? wb_snap : vec_word;
  assign mem_addr = (state == S_WB) ? cfg_wb_addr
                  : {cfg_base, 8'd0} + 40'(wptr) + 40'({widx, 2'b00});

  always_ff @(posedge clk) begin
    if (push) fifo_q[f_wr] <= {ev_pasid, ev_vmid, ev_ring, ev_data, ev_src};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      widx    <= '0;
      f_wr    <= '0;
      f_rd    <= '0;
      f_cnt   <= '0;
      wptr    <= '0;
      rptr    <= '0;
      ovf     <= 1'b0;
      gap     <= 1'b0;
      wb_snap <= '0;
    end else begin
      gap   <= rptr_we && cfg_rearm;
      ovf   <= ovf_new;
      f_cnt <= f_cnt + (FA_W+1)'(push) - (FA_W+1)'(commit);
      if (push)   f_wr <= f_wr + 1'b1;
      if (commit) begin
        f_rd    <= f_rd + 1'b1;
        wb_snap <= {{(32-PTR_W){1'b0}}, wptr_nxt[PTR_W-1:1], ovf_new};
      end
      if (ptr_zero && !cfg_ring_en) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (commit)  wptr <= wptr_nxt;
        if (rptr_we) rptr <= rptr_wdata & mask;
      end
      case (state)
        S_IDLE: if (start) begin
          state <= S_VEC;
          widx  <= '0;
        end
        S_VEC: if (mem_ready) begin
          widx <= widx + 1'b1;
          if (widx == 2'd3) state <= cfg_wb_en ? S_WB : S_IDLE;
        end
        S_WB: if (mem_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module irq_ring_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [39:0] mem_addr,
  input logic [31:0] mem_data,
  input logic [31:0] wptr_stat,
  input logic        irq,
  input logic        rptr_we,
  input logic        cfg_rearm,
  input logic        cfg_ring_en,
  input logic        cfg_intr_en,
  input logic        ovf_clear,
  input logic        ev_valid,
  input logic        ev_ready
);
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready && cfg_ring_en |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R2
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready && cfg_ring_en |=> $stable(wptr_stat[31:1])); // R2
  AST_PTR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_stat[3:1] == 3'd0); // R3
  AST_REARM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_we && cfg_rearm |=> !irq); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_stat[0] && !ovf_clear |=> wptr_stat[0]); // R7
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clear |=> !wptr_stat[0]); // R7
  AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid && !(cfg_intr_en && cfg_ring_en) |=> !mem_valid); // R9
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready && !(mem_valid && mem_ready) |=> !ev_ready); // R10
endmodule

bind irq_ring_writer irq_ring_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .wptr_stat(wptr_stat), .irq(irq),
  .rptr_we(rptr_we), .cfg_rearm(cfg_rearm), .cfg_ring_en(cfg_ring_en),
  .cfg_intr_en(cfg_intr_en), .ovf_clear(ovf_clear), .ev_valid(ev_valid),
  .ev_ready(ev_ready)
);

// File: tb/irq_ring_writer_test.sv
`timescale 1ns/1ps
module irq_ring_writer_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ev_valid = 0, ev_ready;
  logic [7:0]  ev_src = 0, ev_ring = 0, ev_vmid = 0;
  logic [27:0] ev_data = 0;
  logic [15:0] ev_pasid = 0;
  logic        cfg_intr_en = 0, cfg_ring_en = 0, cfg_ovf_en = 0, cfg_wb_en = 0, cfg_rearm = 0;
  logic [31:0] cfg_base = 32'h12;
  logic [4:0]  cfg_log2 = 5'd6;
  logic [39:0] cfg_wb_addr = 40'hAB_0000_0040;
  logic        ovf_clear = 0, ptr_zero = 0, rptr_we = 0;
  logic [17:0] rptr_wdata = 0;
  logic        mem_valid, mem_ready = 1'b1;
  logic [39:0] mem_addr;
  logic [31:0] mem_data, wptr_stat;
  logic        irq;

  always #4 clk = ~clk;

  irq_ring_writer uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src(ev_src), .ev_data(ev_data), .ev_ring(ev_ring), .ev_vmid(ev_vmid),
    .ev_pasid(ev_pasid), .cfg_intr_en(cfg_intr_en), .cfg_ring_en(cfg_ring_en),
    .cfg_ovf_en(cfg_ovf_en), .cfg_wb_en(cfg_wb_en), .cfg_rearm(cfg_rearm),
    .cfg_base(cfg_base), .cfg_log2(cfg_log2), .cfg_wb_addr(cfg_wb_addr),
    .ovf_clear(ovf_clear), .ptr_zero(ptr_zero), .rptr_we(rptr_we),
    .rptr_wdata(rptr_wdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .wptr_stat(wptr_stat), .irq(irq)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, nlog = 0;
  logic stall = 1'b0;
  logic [39:0] la [0:511];
  logic [31:0] ld [0:511];
  localparam logic [39:0] RB = 40'h1200;

  always @(negedge clk) begin
    cyc++;
    mem_ready = stall ? (cyc % 3 == 0) : 1'b1;
    if (rst_n && mem_valid && mem_ready && nlog < 512) begin
      la[nlog] = mem_addr;
      ld[nlog] = mem_data;
      nlog++;
    end
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] s, input logic [27:0] d, input logic [7:0] r,
                      input logic [7:0] v, input logic [15:0] p);
    ev_src = s; ev_data = d; ev_ring = r; ev_vmid = v; ev_pasid = p;
    ev_valid = 1'b1;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic wait_log(input int n);
    while (nlog < n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_rptr(input logic [17:0] v);
    rptr_wdata = v; rptr_we = 1'b1;
    @(negedge clk);
    rptr_we = 1'b0;
  endtask

  task automatic pulse_clear();
    ovf_clear = 1'b1;
    @(negedge clk);
    ovf_clear = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 wptr_stat", wptr_stat, 0);
    chk("R12 irq", irq, 0);
    chk("R12 mem_valid", mem_valid, 0);
    chk("R12 ev_ready", ev_ready, 1);
  endtask

  task automatic t_single();
    int s0 = nlog;
    cfg_intr_en = 1; cfg_ring_en = 1; stall = 1'b1;
    send(8'hA5, 28'hABCDEF1, 8'h03, 8'h07, 16'hBEEF);
    while (nlog < s0 + 3) @(negedge clk);
    chk("R2 pointer held mid-vector", wptr_stat, 0);
    wait_log(s0 + 4);
    for (int k = 0; k < 4; k++) chk("R2 word address", la[s0+k], RB + 40'(4*k));
    chk("R1 word0", ld[s0], 32'h0000_00A5);
    chk("R1 word1", ld[s0+1], 32'h0ABC_DEF1);
    chk("R1 word2", ld[s0+2], 32'hBEEF_0703);
    chk("R1 word3", ld[s0+3], 32'h0);
    chk("R2 pointer after vector", wptr_stat, 32'h10);
    chk("R4 irq pending", irq, 1);
    stall = 1'b0;
  endtask

  task automatic t_irq();
    int s0;
    set_rptr(18'h10);
    chk("R4 irq idle", irq, 0);
    s0 = nlog;
    send(8'h01, 28'h1, 8'h0, 8'h0, 16'h0);
    send(8'h02, 28'h2, 8'h0, 8'h0, 16'h0);
    wait_log(s0 + 8);
    chk("R2 pointer 48", wptr_stat, 32'h30);
    cfg_rearm = 1;
    set_rptr(18'h20);
    chk("R5 rearm gap", irq, 0);
    @(negedge clk);
    chk("R5 rearm reassert", irq, 1);
    cfg_rearm = 0;
    set_rptr(18'h20);
    chk("R5 no gap without rearm", irq, 1);
    cfg_intr_en = 0;
    @(negedge clk);
    chk("R4 irq gated by enable", irq, 0);
    cfg_intr_en = 1;
    set_rptr(18'h30);
    chk("R4 irq drained", irq, 0);
  endtask

  task automatic t_zero();
    ptr_zero = 1; @(negedge clk); ptr_zero = 0;
    chk("R11 zero ignored while enabled", wptr_stat, 32'h30);
    cfg_ring_en = 0; ptr_zero = 1; @(negedge clk); ptr_zero = 0; cfg_ring_en = 1;
    chk("R11 zero while disabled", wptr_stat, 0);
    chk("R11 irq after zero", irq, 0);
  endtask

  task automatic t_wrap();
    cfg_log2 = 5'd4;
    for (int k = 0; k < 4; k++) begin
      int s0 = nlog;
      send(8'h20 + 8'(k), 28'h0, 8'h0, 8'h0, 16'h0);
      wait_log(s0 + 4);
      chk("R3 vector address", la[s0], RB + 40'(16*k));
      set_rptr(18'((16*(k+1)) & 63));
    end
    chk("R3 pointer wrapped", wptr_stat, 0);
    set_rptr(18'h40);
    chk("R3 read pointer masked", irq, 0);
  endtask

  task automatic t_ovf();
    int s0 = nlog;
    cfg_ovf_en = 1;
    for (int k = 0; k < 3; k++) send(8'h30, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_log(s0 + 12);
    chk("R6 no flag before lap", wptr_stat, 32'h30);
    send(8'h31, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_log(s0 + 16);
    chk("R6 flag on lap", wptr_stat, 32'h01);
    send(8'h32, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_log(s0 + 20);
    chk("R6 overwrite oldest", la[s0+16], RB);
    chk("R7 flag sticky", wptr_stat, 32'h11);
    pulse_clear();
    chk("R7 flag cleared", wptr_stat, 32'h10);
    ovf_clear = 1;
    for (int k = 0; k < 3; k++) send(8'h33, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_log(s0 + 32);
    chk("R7 no set while clear held", wptr_stat, 32'h00);
    ovf_clear = 0;
    for (int k = 0; k < 4; k++) send(8'h34, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_log(s0 + 48);
    chk("R7 detection re-armed", wptr_stat, 32'h01);
    pulse_clear();
    cfg_ovf_en = 0;
    for (int k = 0; k < 4; k++) send(8'h35, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_log(s0 + 64);
    chk("R6 no flag when disabled", wptr_stat, 32'h00);
  endtask

  task automatic t_wb();
    int s0 = nlog;
    cfg_wb_en = 1;
    send(8'h40, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_log(s0 + 5);
    chk("R8 mirror address", la[s0+4], 40'hAB_0000_0040);
    chk("R8 mirror data", ld[s0+4], 32'h10);
    cfg_ovf_en = 1;
    for (int k = 0; k < 3; k++) send(8'h41, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_log(s0 + 20);
    chk("R8 mirror carries flag", ld[s0+19], 32'h01);
    pulse_clear();
    cfg_wb_en = 0; cfg_ovf_en = 0;
  endtask

  task automatic t_gate();
    int s0;
    cfg_ring_en = 0;
    send(8'h50, 28'h0, 8'h0, 8'h0, 16'h0);
    s0 = nlog;
    repeat (20) @(negedge clk);
    chk("R9 no write with ring off", nlog, s0);
    cfg_ring_en = 1; cfg_intr_en = 0;
    repeat (20) @(negedge clk);
    chk("R9 no write with intr off", nlog, s0);
    chk("R9 port idle", mem_valid, 0);
    cfg_intr_en = 1;
    wait_log(s0 + 4);
    chk("R9 queued event written", ld[s0], 32'h50);
  endtask

  task automatic t_bp();
    int s0 = nlog;
    cfg_ring_en = 0;
    for (int k = 0; k < 4; k++) send(8'h61 + 8'(k), 28'h0, 8'h0, 8'h0, 16'h0);
    chk("R10 ready low when full", ev_ready, 0);
    cfg_ring_en = 1;
    send(8'h65, 28'h0, 8'h0, 8'h0, 16'h0);
    wait_log(s0 + 20);
    for (int k = 0; k < 5; k++) chk("R10 arrival order", ld[s0+4*k], 32'h61 + 32'(k));
    chk("R10 ready after drain", ev_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_irq();
    t_zero();
    t_wrap();
    t_ovf();
    t_wb();
    t_gate();
    t_bp();
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule